// File: doc/BRIEF.md
# Redundant Clock Monitor and Switch Controller

This block keeps watch over two candidate clock inputs from a faster, free-running reference clock. Each input passes through its own synchronizer, and the block looks for level changes in the synchronized samples. An input that holds one level, high or low, for longer than a parameterised number of reference cycles is declared dead. Its alarm flag is then set and stays set. The reference cycle count should cover one nominal period of the input plus some margin.

The block drives the select line of an external clock multiplexer and reports which input is in use. When the input now in use is flagged dead and the other input is healthy, the select line moves to the healthy input. A failure on the input that is not in use only raises that input's alarm.

When both inputs are dead, the selection stays where it is. A manual override makes the selection follow the preferred-input pin whatever the alarms say. An alarm-clear pulse drops both alarms and leaves the selection as it is. All inputs and outputs belong to the reference clock domain, except the two monitored clocks.

Top module: `clkmon_switch`

## Requirements
- R1: A monitored input whose synchronized level stops changing, whether stuck high or stuck low, raises its alarm `clk_bad[i]` (bit i belongs to `clk_in[i]`). The alarm does not rise within LIMIT+1 reference cycles of the last level change of the pin. It rises no later than LIMIT+5 reference cycles after that change.
- R2: An input whose level changes at least once every LIMIT-2 reference cycles is never flagged, whatever the pattern of the other input.
- R3: Both inputs are monitored at all times, whichever one is selected. A raised alarm stays high until an alarm clear or a master reset.
- R4: With override low, when the selected input's alarm is high and the other input's alarm is low, `mux_sel` changes to the other input one reference cycle after the alarm rises. `mux_sel` = 0 selects `clk_in[0]` and 1 selects `clk_in[1]`.
- R5: With override low, `mux_sel` does not change while the alarm of the selected input is low. This includes the case where the unselected input fails.
- R6: When both alarms are high and override is low, `mux_sel` holds its value.
- R7: A high `alarm_clr` sampled on a reference edge clears both alarms on that edge and restarts both stuck counters. It leaves `mux_sel` unchanged. A later failure sets an alarm again.
- R8: While `force_pref` is high, `mux_sel` takes the value `pref_sel` had one reference cycle earlier, whatever the alarms are. The alarms keep updating during override.
- R9: While `rst_n` is low, both alarms are 0 and `mux_sel` and `in_use` follow `pref_sel`. After release, the selection starts at the `pref_sel` value.
- R10: `in_use` equals the value `mux_sel` had one reference cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock, faster than both monitored inputs |
| rst_n | input | 1 | Master reset, active low, asynchronous assert, synchronous release |
| clk_in | input | 2 | The two monitored clocks; bit i is input i |
| pref_sel | input | 1 | Preferred input: 0 or 1 |
| force_pref | input | 1 | Manual override: selection follows pref_sel |
| alarm_clr | input | 1 | Clears both alarms when high on a reference edge |
| clk_bad | output | 2 | Latched per-input failure alarms |
| mux_sel | output | 1 | Select line for the external clock multiplexer |
| in_use | output | 1 | Input currently in use (mux_sel delayed one cycle) |

## Verification
The bench builds the block with LIMIT = 8 and a two-stage synchronizer. With these values a stuck-input detection completes in about a dozen reference cycles. That makes it practical to sweep every pair of half-periods from 1 to LIMIT-2 for both inputs. It also makes it practical to fail each input at each stuck level with each input preferred. The bench checks each detection against a window on both sides of LIMIT. It then walks through the switch, alarm-clear, unselected-failure, both-dead and override orderings one after another.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  localparam int unsigned NUM_IN = 2;
  typedef logic [NUM_IN-1:0] in_vec_t;

  // index of the other input of the pair
  function automatic logic peer(input logic s);
    return ~s;
  endfunction
endpackage

// File: rtl/clkmon_sync_edge.sv
module clkmon_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], din};
    end else begin : g_single
      always_comb chain_d = din;
    end
  endgenerate

  always_comb prev_d = chain_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  // a level change between successive synchronized samples
  always_comb edge_o = chain_q[LAST] ^ prev_q;
endmodule

// File: rtl/clkmon_stuck_det.sv
module clkmon_stuck_det #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic clr_i,
  output logic bad_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bad_q, bad_d;
  logic             stuck;

  always_comb stuck = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || edge_i) begin
      cnt_d = '0;
    end else if (!stuck) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    bad_d = bad_q;
    if (clr_i) begin
      bad_d = 1'b0;
    end else if (stuck) begin
      bad_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bad_q <= bad_d;
    end
  end

  always_comb bad_o = bad_q;
endmodule

// File: rtl/clkmon_sel_ctl.sv
module clkmon_sel_ctl
  import clkmon_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  in_vec_t bad_i,
  input  logic    pref_sel,
  input  logic    force_pref,
  output logic    mux_sel,
  output logic    in_use,
  output logic    run_o
);
  logic run_q, run_d;
  logic sel_q, sel_d;
  logic use_q, use_d;
  logic other;

  always_comb other = peer(sel_q);

  always_comb begin
    sel_d = sel_q;
    if (!run_q || force_pref) begin
      sel_d = pref_sel;
    end else if (bad_i[sel_q] && !bad_i[other]) begin
      sel_d = other;
    end
  end

  always_comb run_d = 1'b1;
  always_comb use_d = mux_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sel_q <= 1'b0;
      use_q <= 1'b0;
    end else begin
      run_q <= run_d;
      sel_q <= sel_d;
      use_q <= use_d;
    end
  end

  // before the first running cycle the preferred input is presented
  always_comb mux_sel = run_q ? sel_q : pref_sel;
  always_comb in_use  = run_q ? use_q : pref_sel;
  always_comb run_o   = run_q;
endmodule

// File: rtl/clkmon_switch.sv
module clkmon_switch
  import clkmon_pkg::*;
#(
  parameter int unsigned LIMIT       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [1:0] clk_in,
  input  logic       pref_sel,
  input  logic       force_pref,
  input  logic       alarm_clr,
  output logic [1:0] clk_bad,
  output logic       mux_sel,
  output logic       in_use
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  in_vec_t    edge_w;
  in_vec_t    bad_w;
  logic       run_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  always_comb rst_sync_n = rst_pipe_q[1];

  generate
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_mon
      clkmon_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (ref_clk),
        .rst_n  (rst_sync_n),
        .din    (clk_in[gi]),
        .edge_o (edge_w[gi])
      );
      clkmon_stuck_det #(.LIMIT(LIMIT)) u_det (
        .clk    (ref_clk),
        .rst_n  (rst_sync_n),
        .edge_i (edge_w[gi]),
        .clr_i  (alarm_clr),
        .bad_o  (bad_w[gi])
      );
    end
  endgenerate

  clkmon_sel_ctl u_sel (
    .clk        (ref_clk),
    .rst_n      (rst_sync_n),
    .bad_i      (bad_w),
    .pref_sel   (pref_sel),
    .force_pref (force_pref),
    .mux_sel    (mux_sel),
    .in_use     (in_use),
    .run_o      (run_w)
  );

  always_comb clk_bad = bad_w;
endmodule

// File: rtl/clkmon_switch_chk.sv
module clkmon_switch_chk (
  input logic       ref_clk,
  input logic       run,
  input logic [1:0] clk_bad,
  input logic       mux_sel,
  input logic       in_use,
  input logic       pref_sel,
  input logic       force_pref,
  input logic       alarm_clr
);
  // R3
  alarm_hold_chk: assert property (@(posedge ref_clk) disable iff (!run)
    !alarm_clr |=> ((clk_bad & $past(clk_bad)) == $past(clk_bad)));

  // R7
  alarm_clear_chk: assert property (@(posedge ref_clk) disable iff (!run)
    alarm_clr |=> (clk_bad == 2'b00));

  // R5
  healthy_hold_chk: assert property (@(posedge ref_clk) disable iff (!run)
    (!force_pref && !clk_bad[mux_sel]) |=> $stable(mux_sel));

  // R6
  both_bad_hold_chk: assert property (@(posedge ref_clk) disable iff (!run)
    (!force_pref && (clk_bad == 2'b11)) |=> $stable(mux_sel));

  // R8
  override_follow_chk: assert property (@(posedge ref_clk) disable iff (!run)
    force_pref |=> (mux_sel == $past(pref_sel)));

  // R10
  in_use_lag_chk: assert property (@(posedge ref_clk) disable iff (!run)
    1'b1 |=> (in_use == $past(mux_sel)));
endmodule

bind clkmon_switch clkmon_switch_chk u_chk (
  .ref_clk    (ref_clk),
  .run        (run_w),
  .clk_bad    (clk_bad),
  .mux_sel    (mux_sel),
  .in_use     (in_use),
  .pref_sel   (pref_sel),
  .force_pref (force_pref),
  .alarm_clr  (alarm_clr)
);

// File: tb/sim_clkmon_switch.sv
module sim_clkmon_switch;
  localparam int LIMIT = 8;

  logic       ref_clk = 1'b0;
  logic       rst_n;
  logic [1:0] clk_in;
  logic       pref_sel, force_pref, alarm_clr;
  wire  [1:0] clk_bad;
  wire        mux_sel, in_use;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] run_g = 2'b00;
  logic [1:0] lvl_g = 2'b00;
  int half_g [2] = '{3, 4};
  int ph_g   [2] = '{0, 0};

  always #5 ref_clk = ~ref_clk;

  clkmon_switch #(.LIMIT(LIMIT), .SYNC_STAGES(2)) u0 (
    .ref_clk(ref_clk), .rst_n(rst_n), .clk_in(clk_in), .pref_sel(pref_sel),
    .force_pref(force_pref), .alarm_clr(alarm_clr), .clk_bad(clk_bad),
    .mux_sel(mux_sel), .in_use(in_use)
  );

  // input clock generators, stepped on the falling reference edge
  always @(negedge ref_clk) begin
    for (int i = 0; i < 2; i++) begin
      if (run_g[i]) begin
        if (ph_g[i] >= half_g[i] - 1) begin
          clk_in[i] <= ~clk_in[i];
          ph_g[i]   <= 0;
        end else begin
          ph_g[i] <= ph_g[i] + 1;
        end
      end else begin
        clk_in[i] <= lvl_g[i];
        ph_g[i]   <= 0;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
    #2;
  endtask

  task automatic start_in(input int i, input int h);
    half_g[i] = h;
    run_g[i]  = 1'b1;
  endtask

  // stop input i so that it freezes at 'level' with a fresh edge
  task automatic stop_in(input int i, input logic level);
    while (clk_in[i] !== ~level) cyc(1);
    lvl_g[i] = level;
    run_g[i] = 1'b0;
  endtask

  task automatic pulse_clear();
    alarm_clr = 1'b1;
    cyc(1);
    alarm_clr = 1'b0;
  endtask

  task automatic fail_check(input int i, input logic level, input logic exp_sel,
                            input string r);
    stop_in(i, level);
    cyc(LIMIT + 2);
    chk("R1 early", clk_bad[i], 1'b0);
    cyc(5);
    chk("R1 late", clk_bad[i], 1'b1);
    cyc(2);
    chk(r, mux_sel, exp_sel);
    chk("R10 settle", in_use, exp_sel);
  endtask

  task automatic do_reset(input logic p);
    rst_n    = 1'b0;
    pref_sel = p;
    run_g    = 2'b00;
    cyc(3);
    chk("R9 flags", clk_bad, 2'b00);
    chk("R9 mux", mux_sel, p);
    chk("R9 use", in_use, p);
    rst_n = 1'b1;
    start_in(0, 3);
    start_in(1, 4);
    cyc(12);
    chk("R9 start", mux_sel, p);
  endtask

  initial begin
    cyc(150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pref_sel = 1'b0; force_pref = 1'b0; alarm_clr = 1'b0;
    cyc(3);
    chk("R9 reset flags", clk_bad, 2'b00);
    chk("R9 reset mux", mux_sel, 1'b0);
    chk("R9 reset use", in_use, 1'b0);
    pref_sel = 1'b1;
    cyc(1);
    chk("R9 reset follows pref", mux_sel, 1'b1);
    chk("R9 reset use follows", in_use, 1'b1);
    do_reset(1'b0);

    // R2: sweep of half-periods on both inputs
    for (int h0 = 1; h0 <= LIMIT - 2; h0++) begin
      for (int h1 = 1; h1 <= LIMIT - 2; h1++) begin
        half_g[0] = h0;
        half_g[1] = h1;
        cyc(2 * LIMIT + 10);
        chk("R2 healthy", clk_bad, 2'b00);
        chk("R2 no switch", mux_sel, 1'b0);
      end
    end

    for (int i = 0; i < 2; i++) begin
      for (int lv = 0; lv < 2; lv++) begin
        logic si;
        logic so;
        si = 1'(i);
        so = ~si;
        do_reset(si);
        // R4: selected input dies, healthy peer takes over
        fail_check(i, 1'(lv), so, "R4 switch");
        chk("R3 peer alarm clear", clk_bad[so], 1'b0);
        // R7: alarm clear keeps the selection
        start_in(i, 2);
        cyc(10);
        chk("R3 latched", clk_bad[si], 1'b1);
        pulse_clear();
        chk("R7 cleared", clk_bad, 2'b00);
        chk("R7 sel kept", mux_sel, so);
        cyc(20);
        chk("R7 stays clear", clk_bad, 2'b00);
        // R5: unselected input dies, selection unchanged; R7 fresh set
        fail_check(i, 1'(1 - lv), so, "R5 no switch");
        chk("R3 selected alarm", clk_bad[so], 1'b0);
        // R6: the selected input dies too
        fail_check(int'(so), 1'(lv), so, "R6 both bad hold");
        cyc(20);
        chk("R6 still held", mux_sel, so);
        chk("R6 both flags", clk_bad, 2'b11);
        // R8: override follows pref, alarms keep working
        force_pref = 1'b1;
        pref_sel   = si;
        cyc(1);
        chk("R8 follow", mux_sel, si);
        chk("R10 lag", in_use, so);
        cyc(1);
        chk("R10 after", in_use, si);
        pref_sel = so;
        cyc(1);
        chk("R8 follow back", mux_sel, so);
        pulse_clear();
        chk("R8 clear under override", clk_bad, 2'b00);
        cyc(LIMIT + 8);
        chk("R8 alarms update", clk_bad, 2'b11);
        force_pref = 1'b0;
        cyc(5);
        chk("R6 hold after override", mux_sel, so);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule